// File: doc/BRIEF.md
# Reservation Station Pool with Broadcast Capture

This block holds a handful of instructions waiting to run on a single functional unit. An instruction is written into a free slot together with its operation code and two source operands. Each source is either a finished value or the tag of the producer that will deliver it later. Every slot watches one shared result bus. When the tag on that bus matches a source the slot is still waiting for, the slot copies the value in. A slot with both values in hand is offered to the functional unit, one slot per cycle. Once the unit's own result appears on the result bus under the slot's tag, the slot is returned to the free set.

The slot tag is the pool's base tag plus the slot index. The issuing side learns the tag from `iss_tag` and forwards it to the renaming logic. The unit takes a dispatched instruction in the cycle it is offered. There is no handshake towards the unit.

Top module: `rs_pool`

## Requirements
- R1: An instruction is accepted on a cycle with `iss_valid` high and `iss_stall` low. `iss_stall` is high exactly when every slot is occupied. An accepted instruction goes into the lowest-index free slot. Its tag, the base tag (default 4) plus that index, is shown on `iss_tag` in the same cycle. An issue attempt while stalled changes nothing.
- R2: A dispatched instruction carries on `disp_op` the operation code it was issued with.
- R3: A source issued with its ready flag low waits on its tag. In any cycle where `bc_valid` is high and `bc_tag` equals that tag, the value on `bc_val` is captured. All waiting sources in all slots that match capture the same broadcast together. A source issued with its ready flag high keeps the issued value.
- R4: A source issued in the same cycle as a broadcast whose tag matches the source's pending tag takes the broadcast value at once.
- R5: `disp_valid` is high only for an occupied, not yet dispatched slot whose two sources both hold values. This first happens in the cycle after the last source becomes available.
- R6: Among several eligible slots, the lowest index is dispatched first, one slot per cycle. `disp_tag` equals the base tag plus the slot index, and it is never zero.
- R7: A dispatched slot stays occupied but is never offered again. A broadcast carrying its own tag frees it, and from the next cycle it counts as free for issue.
- R8: A broadcast carrying the tag of a slot that has not been dispatched leaves that slot occupied.
- R9: After reset all slots are free, `iss_stall` and `disp_valid` are low, and `iss_tag` shows the base tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code |
| iss_a_rdy | input | 1 | Source A holds a value (1) or a pending tag (0) |
| iss_a_val | input | DATA_W | Source A value |
| iss_a_tag | input | TAG_W | Source A producer tag |
| iss_b_rdy | input | 1 | Source B holds a value (1) or a pending tag (0) |
| iss_b_val | input | DATA_W | Source B value |
| iss_b_tag | input | TAG_W | Source B producer tag |
| iss_stall | output | 1 | All slots occupied, issue refused |
| iss_tag | output | TAG_W | Tag given to the instruction accepted this cycle |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_val | input | DATA_W | Broadcast result value |
| disp_valid | output | 1 | An instruction is dispatched to the unit this cycle |
| disp_op | output | OP_W | Dispatched operation code |
| disp_tag | output | TAG_W | Tag of the dispatched slot |
| disp_a | output | DATA_W | Dispatched source A value |
| disp_b | output | DATA_W | Dispatched source B value |

## Verification
`iss_stall` and `iss_tag` depend only on registered slot state. They are due in the same cycle as the issue they govern. The effects of an issue, a capture or a free appear one clock edge later: the slot becomes occupied, a source value is captured, a slot is freed, and a slot becomes eligible for dispatch. The bench drives inputs at the falling edge and keeps a model updated with the same one-edge step. At the next falling edge, before driving again, it compares every output against the model. So a result is always checked in the first cycle it is due and never earlier.

// File: rtl/rs_pool_pkg.sv
package rs_pool_pkg;

   // Lifecycle of one slot.
   typedef enum logic [1:0] {
      ENT_FREE = 2'd0,
      ENT_WAIT = 2'd1,
      ENT_SENT = 2'd2
   } ent_state_e;

endpackage

// File: rtl/rs_operand.sv
module rs_operand #(
   parameter int TAG_W  = 4,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              ld_rdy,
   input  logic [DATA_W-1:0] ld_val,
   input  logic [TAG_W-1:0]  ld_tag,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_val,
   output logic              rdy,
   output logic [DATA_W-1:0] val
);

   logic              rdy_q;
   logic [DATA_W-1:0] val_q;
   logic [TAG_W-1:0]  tag_q;
   logic              hit_load;
   logic              hit_wait;

   always_comb begin
      hit_load = bc_valid && (bc_tag == ld_tag);
      hit_wait = bc_valid && !rdy_q && (bc_tag == tag_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy_q <= 1'b0;
         val_q <= '0;
         tag_q <= '0;
      end else if (load) begin
         tag_q <= ld_tag;
         if (ld_rdy) begin
            rdy_q <= 1'b1;
            val_q <= ld_val;
         end else if (hit_load) begin
            rdy_q <= 1'b1;
            val_q <= bc_val;
         end else begin
            rdy_q <= 1'b0;
         end
      end else if (hit_wait) begin
         rdy_q <= 1'b1;
         val_q <= bc_val;
      end
   end

   assign rdy = rdy_q;
   assign val = val_q;

   // A captured value is held until the source is reloaded.
   assert_value_held_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (rdy && !load) |=> (rdy && $stable(val)));

   // A pending source loaded with a matching broadcast is ready next cycle.
   assert_same_cycle_capture_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (load && !ld_rdy && bc_valid && (bc_tag == ld_tag)) |=> (rdy && (val == $past(bc_val))));

endmodule

// File: rtl/rs_entry.sv
module rs_entry
   import rs_pool_pkg::*;
#(
   parameter int TAG_W  = 4,
   parameter int DATA_W = 16,
   parameter int OP_W   = 4,
   parameter int MY_TAG = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic [OP_W-1:0]   iss_op,
   input  logic              a_rdy,
   input  logic [DATA_W-1:0] a_val,
   input  logic [TAG_W-1:0]  a_tag,
   input  logic              b_rdy,
   input  logic [DATA_W-1:0] b_val,
   input  logic [TAG_W-1:0]  b_tag,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_val,
   input  logic              grant,
   output logic              busy,
   output logic              ready,
   output logic [OP_W-1:0]   op,
   output logic [DATA_W-1:0] a_out,
   output logic [DATA_W-1:0] b_out
);

   localparam logic [TAG_W-1:0] OWN_TAG = TAG_W'(MY_TAG);

   ent_state_e      state_q;
   logic [OP_W-1:0] op_q;
   logic            a_ok;
   logic            b_ok;
   logic            own_done;

   rs_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_src_a (
      .clk(clk), .rst_n(rst_n), .load(alloc),
      .ld_rdy(a_rdy), .ld_val(a_val), .ld_tag(a_tag),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
      .rdy(a_ok), .val(a_out));

   rs_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_src_b (
      .clk(clk), .rst_n(rst_n), .load(alloc),
      .ld_rdy(b_rdy), .ld_val(b_val), .ld_tag(b_tag),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
      .rdy(b_ok), .val(b_out));

   assign own_done = bc_valid && (bc_tag == OWN_TAG);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ENT_FREE;
         op_q    <= '0;
      end else begin
         unique case (state_q)
            ENT_FREE: if (alloc) begin
               state_q <= ENT_WAIT;
               op_q    <= iss_op;
            end
            ENT_WAIT: if (grant) state_q <= ENT_SENT;
            ENT_SENT: if (own_done) state_q <= ENT_FREE;
            default:  state_q <= ENT_FREE;
         endcase
      end
   end

   assign busy  = (state_q != ENT_FREE);
   assign ready = (state_q == ENT_WAIT) && a_ok && b_ok;
   assign op    = op_q;

   // Only a free slot may be written.
   assert_alloc_free_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> (state_q == ENT_FREE));

   // The picker grants only a slot holding both values.
   assert_grant_ready_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> (a_ok && b_ok && busy));

   // After dispatch the slot is not offered again.
   assert_no_redispatch_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      grant |=> (busy && !ready));

   // A waiting slot is never freed by any broadcast.
   assert_wait_kept_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ENT_WAIT) |=> busy);

endmodule

// File: rtl/rs_pick.sv
module rs_pick #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     gnt,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   logic [N:0] seen;

   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign seen[i+1] = seen[i] | req[i];
      assign gnt[i]    = req[i] & ~seen[i];
   end

   assign any = seen[N];

   always_comb begin
      idx = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (req[k]) idx = IDX_W'(k);
      end
   end

endmodule

// File: rtl/rs_pool.sv
module rs_pool #(
   parameter int DEPTH     = 4,
   parameter int TAG_W     = 4,
   parameter int DATA_W    = 16,
   parameter int OP_W      = 4,
   parameter int POOL_BASE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   input  logic [OP_W-1:0]   iss_op,
   input  logic              iss_a_rdy,
   input  logic [DATA_W-1:0] iss_a_val,
   input  logic [TAG_W-1:0]  iss_a_tag,
   input  logic              iss_b_rdy,
   input  logic [DATA_W-1:0] iss_b_val,
   input  logic [TAG_W-1:0]  iss_b_tag,
   output logic              iss_stall,
   output logic [TAG_W-1:0]  iss_tag,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_val,
   output logic              disp_valid,
   output logic [OP_W-1:0]   disp_op,
   output logic [TAG_W-1:0]  disp_tag,
   output logic [DATA_W-1:0] disp_a,
   output logic [DATA_W-1:0] disp_b
);

   localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int TOP_TAG = POOL_BASE + DEPTH - 1;

   if (DEPTH < 1) begin : g_bad_depth
      $error("rs_pool: DEPTH must be at least 1");
   end
   if (POOL_BASE < 1) begin : g_bad_base
      $error("rs_pool: POOL_BASE must be nonzero so that no slot tag is zero");
   end
   if (TOP_TAG >= (1 << TAG_W)) begin : g_bad_tagw
      $error("rs_pool: TAG_W too narrow for POOL_BASE + DEPTH - 1");
   end

   logic [DEPTH-1:0]  busy;
   logic [DEPTH-1:0]  ready;
   logic [DEPTH-1:0]  free_gnt;
   logic [DEPTH-1:0]  disp_gnt;
   logic [DEPTH-1:0]  alloc;
   logic              free_any;
   logic [IDX_W-1:0]  free_idx;
   logic [IDX_W-1:0]  disp_idx;
   logic [OP_W-1:0]   ent_op [DEPTH];
   logic [DATA_W-1:0] ent_a  [DEPTH];
   logic [DATA_W-1:0] ent_b  [DEPTH];
   logic              take;

   rs_pick #(.N(DEPTH), .IDX_W(IDX_W)) u_free_pick (
      .req(~busy), .gnt(free_gnt), .any(free_any), .idx(free_idx));

   rs_pick #(.N(DEPTH), .IDX_W(IDX_W)) u_disp_pick (
      .req(ready), .gnt(disp_gnt), .any(disp_valid), .idx(disp_idx));

   assign iss_stall = ~free_any;
   assign take      = iss_valid & free_any;
   assign alloc     = free_gnt & {DEPTH{take}};
   assign iss_tag   = TAG_W'(POOL_BASE) + TAG_W'(free_idx);

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      rs_entry #(
         .TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W), .MY_TAG(POOL_BASE + i)
      ) u_entry (
         .clk(clk), .rst_n(rst_n), .alloc(alloc[i]), .iss_op(iss_op),
         .a_rdy(iss_a_rdy), .a_val(iss_a_val), .a_tag(iss_a_tag),
         .b_rdy(iss_b_rdy), .b_val(iss_b_val), .b_tag(iss_b_tag),
         .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
         .grant(disp_gnt[i]), .busy(busy[i]), .ready(ready[i]),
         .op(ent_op[i]), .a_out(ent_a[i]), .b_out(ent_b[i]));
   end

   always_comb begin
      disp_op = '0;
      disp_a  = '0;
      disp_b  = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (disp_gnt[k]) begin
            disp_op = ent_op[k];
            disp_a  = ent_a[k];
            disp_b  = ent_b[k];
         end
      end
   end

   assign disp_tag = TAG_W'(POOL_BASE) + TAG_W'(disp_idx);

   // At most one slot is filled per cycle.
   assert_occ_step_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(busy) <= $countones($past(busy)) + 1));

   // A refused issue never fills a slot.
   assert_stall_blocks_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      iss_stall |=> ($countones(busy) <= $countones($past(busy))));

   // One broadcast frees at most one slot.
   assert_free_step_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(busy) + 1 >= $countones($past(busy))));

   // A dispatched tag is never zero.
   assert_tag_nonzero_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |-> (disp_tag != '0));

endmodule

// File: tb/rs_pool_bench.sv
`timescale 1ns/1ps
module rs_pool_bench;

   localparam int D    = 4;
   localparam int BASE = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        iss_valid = 1'b0;
   logic [3:0]  iss_op = '0;
   logic        iss_a_rdy = 1'b0;
   logic [15:0] iss_a_val = '0;
   logic [3:0]  iss_a_tag = '0;
   logic        iss_b_rdy = 1'b0;
   logic [15:0] iss_b_val = '0;
   logic [3:0]  iss_b_tag = '0;
   logic        iss_stall;
   logic [3:0]  iss_tag;
   logic        bc_valid = 1'b0;
   logic [3:0]  bc_tag = '0;
   logic [15:0] bc_val = '0;
   logic        disp_valid;
   logic [3:0]  disp_op;
   logic [3:0]  disp_tag;
   logic [15:0] disp_a;
   logic [15:0] disp_b;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   // Model state: 0 free, 1 waiting, 2 dispatched.
   int          m_st [D];
   logic        m_ar [D];
   logic        m_br [D];
   logic [15:0] m_av [D];
   logic [15:0] m_bv [D];
   logic [3:0]  m_at [D];
   logic [3:0]  m_bt [D];
   logic [3:0]  m_op [D];

   always #5 clk = ~clk;

   rs_pool u_rs_pool (
      .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
      .iss_a_rdy(iss_a_rdy), .iss_a_val(iss_a_val), .iss_a_tag(iss_a_tag),
      .iss_b_rdy(iss_b_rdy), .iss_b_val(iss_b_val), .iss_b_tag(iss_b_tag),
      .iss_stall(iss_stall), .iss_tag(iss_tag),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
      .disp_valid(disp_valid), .disp_op(disp_op), .disp_tag(disp_tag),
      .disp_a(disp_a), .disp_b(disp_b));

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   function automatic int exp_free();
      for (int i = 0; i < D; i++) if (m_st[i] == 0) return i;
      return -1;
   endfunction

   function automatic int exp_disp();
      for (int i = 0; i < D; i++) if (m_st[i] == 1 && m_ar[i] && m_br[i]) return i;
      return -1;
   endfunction

   // One cycle: check outputs against the model, drive, advance the model.
   task automatic cyc(input string ctx, input logic iv, input logic [3:0] op,
                      input logic ar, input logic [15:0] av, input logic [3:0] at,
                      input logic br, input logic [15:0] bv, input logic [3:0] bt,
                      input logic bcv, input logic [3:0] bct, input logic [15:0] bcd);
      int fi;
      int di;
      @(negedge clk);
      fi = exp_free();
      di = exp_disp();
      check({ctx, " R1 stall"}, 32'(iss_stall), 32'(fi < 0));
      if (fi >= 0) check({ctx, " R1 iss_tag"}, 32'(iss_tag), 32'(BASE + fi));
      check({ctx, " R5 disp_valid"}, 32'(disp_valid), 32'(di >= 0));
      if (di >= 0) begin
         check({ctx, " R6 disp_tag"}, 32'(disp_tag), 32'(BASE + di));
         check({ctx, " R2 disp_op"}, 32'(disp_op), 32'(m_op[di]));
         check({ctx, " R3 disp_a"}, 32'(disp_a), 32'(m_av[di]));
         check({ctx, " R3 disp_b"}, 32'(disp_b), 32'(m_bv[di]));
      end
      iss_valid = iv; iss_op = op;
      iss_a_rdy = ar; iss_a_val = av; iss_a_tag = at;
      iss_b_rdy = br; iss_b_val = bv; iss_b_tag = bt;
      bc_valid = bcv; bc_tag = bct; bc_val = bcd;
      for (int i = 0; i < D; i++) begin
         if (bcv && !m_ar[i] && m_at[i] == bct) begin m_ar[i] = 1'b1; m_av[i] = bcd; end
         if (bcv && !m_br[i] && m_bt[i] == bct) begin m_br[i] = 1'b1; m_bv[i] = bcd; end
         if (m_st[i] == 2 && bcv && bct == 4'(BASE + i)) m_st[i] = 0;
      end
      if (di >= 0) m_st[di] = 2;
      if (iv && fi >= 0) begin
         m_st[fi] = 1; m_op[fi] = op;
         m_at[fi] = at; m_bt[fi] = bt;
         m_ar[fi] = ar || (bcv && bct == at);
         m_av[fi] = ar ? av : bcd;
         m_br[fi] = br || (bcv && bct == bt);
         m_bv[fi] = br ? bv : bcd;
      end
   endtask

   task automatic idle(input string ctx);
      cyc(ctx, 1'b0, 4'd0, 1'b1, 16'd0, 4'd0, 1'b1, 16'd0, 4'd0, 1'b0, 4'd0, 16'd0);
   endtask

   initial begin
      int seed;
      for (int i = 0; i < D; i++) begin
         m_st[i] = 0; m_ar[i] = 1'b0; m_br[i] = 1'b0; m_av[i] = '0; m_bv[i] = '0;
         m_at[i] = '0; m_bt[i] = '0; m_op[i] = '0;
      end
      seed = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9: reset state at the first sample after release.
      @(negedge clk);
      check("R9 stall after reset", 32'(iss_stall), 32'd0);
      check("R9 disp_valid after reset", 32'(disp_valid), 32'd0);
      check("R9 iss_tag after reset", 32'(iss_tag), 32'(BASE));

      // Fill the pool; source A waits on external tag 1.
      for (int i = 0; i < D; i++)
         cyc("R1 fill", 1'b1, 4'(i + 3), 1'b0, 16'd0, 4'd1, 1'b1, 16'(100 + i), 4'd0,
             1'b0, 4'd0, 16'd0);
      // Issue while full is ignored.
      cyc("R1 issue while full", 1'b1, 4'hF, 1'b1, 16'hDEAD, 4'd0, 1'b1, 16'hBEEF, 4'd0,
          1'b0, 4'd0, 16'd0);
      // Tag of a waiting slot on the bus leaves it occupied.
      cyc("R8 foreign tag keeps slot", 1'b0, 4'd0, 1'b1, 16'd0, 4'd0, 1'b1, 16'd0, 4'd0,
          1'b1, 4'(BASE + 1), 16'h5555);
      idle("R8 foreign tag keeps slot");
      // One broadcast wakes every slot; they leave lowest first.
      cyc("R3 shared wakeup", 1'b0, 4'd0, 1'b1, 16'd0, 4'd0, 1'b1, 16'd0, 4'd0,
          1'b1, 4'd1, 16'h1234);
      for (int i = 0; i < D; i++) idle("R6 lowest first");
      // Own tag frees a dispatched slot.
      cyc("R7 free on own tag", 1'b0, 4'd0, 1'b1, 16'd0, 4'd0, 1'b1, 16'd0, 4'd0,
          1'b1, 4'(BASE), 16'h0);
      idle("R7 free on own tag");
      // Same-cycle issue and matching broadcast.
      cyc("R4 same-cycle capture", 1'b1, 4'd9, 1'b0, 16'd0, 4'd2, 1'b0, 16'd0, 4'd2,
          1'b1, 4'd2, 16'hA5A5);
      idle("R4 same-cycle capture");
      for (int i = 1; i < D; i++)
         cyc("R7 drain", 1'b0, 4'd0, 1'b1, 16'd0, 4'd0, 1'b1, 16'd0, 4'd0,
             1'b1, 4'(BASE + i), 16'h0);
      idle("R7 drain");

      // Constrained random traffic.
      for (int n = 0; n < 5000; n++) begin
         logic iv;
         logic ar;
         logic br;
         logic bcv;
         logic [3:0] bct;
         iv  = ($urandom % 3) != 0;
         ar  = ($urandom % 2) != 0;
         br  = ($urandom % 3) != 0;
         bcv = ($urandom % 2) != 0;
         bct = 4'(1 + ($urandom % 7));
         cyc("random", iv, 4'($urandom), ar, 16'($urandom), 4'(1 + ($urandom % 7)),
             br, 16'($urandom), 4'(1 + ($urandom % 7)), bcv, bct, 16'($urandom));
      end
      idle("random");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule